// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block holds the configuration state of one general-purpose I/O port of up to 32 pins and presents it to the pad ring as plain per-pin masks. Six masks are kept: the GPIO-versus-alternate function choice, the output driver enable, the output level, the pin wake enable, and two primary-versus-secondary alternate-function choices. Each mask sits behind three word addresses: a base address that replaces the whole mask, a set address where each 1 bit forces that pin's bit high, and a clear address where each 1 bit forces it low. Firmware can therefore change a single pin with one write and does not need a read-modify-write that could race with another agent.

Access is through a simple single-cycle register bus. A transfer is one cycle with `bus_valid` high. A write is committed on that clock edge. Read data is combinational in the same cycle. The bus has no back-pressure: every presented transfer completes at once, so the bank has no ready signal. Pin levels pass through a two-flop synchronizer and can be read back at a read-only input address.

Top module: `gpio_ctl_bank`

## Requirements
- R1: After reset, all six mask outputs are zero. Every mask base address reads zero, and the input address reads zero until pins propagate.
- R2: Base word offsets are fixed and use address bits [11:2]; bits [1:0] are ignored. The offsets are: function select 0x000, output enable 0x00C, output level 0x018, wake enable 0x04C, alternate-A 0x068, alternate-B 0x074. A write to a base replaces the whole mask, and a read returns it.
- R3: A write to base+0x4 sets every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write to base+0x8 clears every mask bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: Each mask drives its output port directly, with bit i belonging to pin i. Function select: 1 means GPIO and 0 means alternate. Output enable: 1 means the driver is on. Alternate-A/B: 1 means secondary.
- R6: Address 0x024 reads the pin levels through a two-flop synchronizer. A pin change that is set up before clock edge k becomes readable after edge k+1. Writes to 0x024 change nothing.
- R7: Set and clear alias addresses always read zero.
- R8: Any other address in the 4 KiB window reads zero, and a write to it changes no mask.
- R9: A write takes effect on the edge that accepts it, so a read in the next cycle returns the new value. With `bus_valid` low, no mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| pin_in | input | 32 | Raw pin levels |
| func_gpio_o | output | 32 | Function select mask (1 = GPIO) |
| drv_en_o | output | 32 | Output driver enable mask |
| drv_lvl_o | output | 32 | Output level mask |
| wake_en_o | output | 32 | Wake enable mask |
| alt_a_o | output | 32 | Alternate select A (1 = secondary) |
| alt_b_o | output | 32 | Alternate select B (1 = secondary) |

## Verification
Every mask is visible as an output port, so a decode or alias error shows on the pins on the clock edge right after the faulty write. Typical errors are a set alias that drops bits or a clear alias that hits the wrong mask. The bench therefore compares all six outputs against its model after every write, including writes that should have no effect. A wrong read-mux selection is seen in the same cycle as the read. A synchronizer with the wrong depth shows up because the input address is sampled exactly one edge early and exactly on time.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

  localparam int ADDR_W    = 12;
  localparam int NUM_MASKS = 6;
  localparam int SYNC_DEPTH = 2;

  // word offset (byte offset >> 2) of the input register
  localparam logic [ADDR_W-3:0] IN_WORD = 10'h009;

  typedef enum int {
    M_FUNC  = 0,
    M_DRVEN = 1,
    M_LEVEL = 2,
    M_WAKE  = 3,
    M_ALTA  = 4,
    M_ALTB  = 5
  } mask_id_e;

  // byte offset of a mask base; set alias at +4, clear alias at +8
  function automatic logic [ADDR_W-1:0] mask_base(input int idx);
    case (idx)
      M_FUNC:  mask_base = 12'h000;
      M_DRVEN: mask_base = 12'h00C;
      M_LEVEL: mask_base = 12'h018;
      M_WAKE:  mask_base = 12'h04C;
      M_ALTA:  mask_base = 12'h068;
      M_ALTB:  mask_base = 12'h074;
      default: mask_base = 12'hFFC;
    endcase
  endfunction

endpackage

// File: rtl/gpio_ctl_decode.sv
module gpio_ctl_decode
  import gpio_ctl_pkg::*;
#(
  parameter int N_MASK = NUM_MASKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_MASK-1:0] sel_base,
  output logic [N_MASK-1:0] sel_set,
  output logic [N_MASK-1:0] sel_clr,
  output logic              sel_in
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  for (genvar g = 0; g < N_MASK; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] BASE = mask_base(g);
    localparam logic [WORD_W-1:0] BW   = BASE[ADDR_W-1:2];
    assign sel_base[g] = (word == BW);
    assign sel_set[g]  = (word == BW + WORD_W'(1));
    assign sel_clr[g]  = (word == BW + WORD_W'(2));
  end

  assign sel_in = (word == IN_WORD);

  // R2: an address never selects two targets
  p_decode_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_base, sel_set, sel_clr, sel_in}));

endmodule

// File: rtl/gpio_ctl_mask.sv
module gpio_ctl_mask #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_en)  q <= wdata;
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end

  // R3: set alias raises written ones and keeps existing ones
  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (((q & $past(wdata)) == $past(wdata)) &&
                ((q & $past(q)) == $past(q))));

  // R4: clear alias drops written ones and raises nothing
  p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (((q & $past(wdata)) == '0) &&
                ((q | $past(q)) == $past(q))));

  // R9: no strobe, no change
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || set_en || clr_en) |=> $stable(q));

endmodule

// File: rtl/gpio_ctl_sync.sv
module gpio_ctl_sync
  import gpio_ctl_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [SYNC_DEPTH];

  for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else             stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[SYNC_DEPTH-1];

  // count edges out of reset so the latency check never looks into reset
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R6: pins reach the read path exactly two edges later
  p_in_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_ctl_bank.sv
module gpio_ctl_bank
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] func_gpio_o,
  output logic [NUM_PINS-1:0] drv_en_o,
  output logic [NUM_PINS-1:0] drv_lvl_o,
  output logic [NUM_PINS-1:0] wake_en_o,
  output logic [NUM_PINS-1:0] alt_a_o,
  output logic [NUM_PINS-1:0] alt_b_o
);
  logic [NUM_MASKS-1:0] sel_base, sel_set, sel_clr;
  logic                 sel_in;
  logic                 wr_go, rd_go;
  logic [NUM_PINS-1:0]  mask_q [NUM_MASKS];
  logic [NUM_PINS-1:0]  in_sync;

  assign wr_go = bus_valid && bus_write;
  assign rd_go = bus_valid && !bus_write;

  gpio_ctl_decode #(.N_MASK(NUM_MASKS)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .sel_base (sel_base),
    .sel_set  (sel_set),
    .sel_clr  (sel_clr),
    .sel_in   (sel_in)
  );

  for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
    gpio_ctl_mask #(.WIDTH(NUM_PINS)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_go && sel_base[m]),
      .set_en (wr_go && sel_set[m]),
      .clr_en (wr_go && sel_clr[m]),
      .wdata  (bus_wdata),
      .q      (mask_q[m])
    );
  end

  gpio_ctl_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      for (int m = 0; m < NUM_MASKS; m++)
        if (sel_base[m]) bus_rdata = mask_q[m];
      if (sel_in) bus_rdata = in_sync;
    end
  end

  assign func_gpio_o = mask_q[M_FUNC];
  assign drv_en_o    = mask_q[M_DRVEN];
  assign drv_lvl_o   = mask_q[M_LEVEL];
  assign wake_en_o   = mask_q[M_WAKE];
  assign alt_a_o     = mask_q[M_ALTA];
  assign alt_b_o     = mask_q[M_ALTB];

  // R7: alias addresses read back zero
  p_alias_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && (|{sel_set, sel_clr})) |-> (bus_rdata == '0));

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !(|{sel_base, sel_set, sel_clr, sel_in})) |-> (bus_rdata == '0));

  // R8: unmapped writes leave all outputs alone
  p_unmapped_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !(|{sel_base, sel_set, sel_clr})) |=>
      ($stable(func_gpio_o) && $stable(drv_en_o) && $stable(drv_lvl_o) &&
       $stable(wake_en_o) && $stable(alt_a_o) && $stable(alt_b_o)));

endmodule

// File: tb/gpio_ctl_bank_test.sv
module gpio_ctl_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] func_gpio_o, drv_en_o, drv_lvl_o, wake_en_o, alt_a_o, alt_b_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_m [6];
  logic [11:0] base_of [6] = '{12'h000, 12'h00C, 12'h018, 12'h04C, 12'h068, 12'h074};

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctl_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .func_gpio_o(func_gpio_o), .drv_en_o(drv_en_o),
    .drv_lvl_o(drv_lvl_o), .wake_en_o(wake_en_o), .alt_a_o(alt_a_o),
    .alt_b_o(alt_b_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] out_of(input int i);
    case (i)
      0: out_of = func_gpio_o;
      1: out_of = drv_en_o;
      2: out_of = drv_lvl_o;
      3: out_of = wake_en_o;
      4: out_of = alt_a_o;
      default: out_of = alt_b_o;
    endcase
  endfunction

  // all tasks start and end just after a falling edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic check_all(input string req, input string what);
    logic [31:0] rd;
    for (int i = 0; i < 6; i++) begin
      check(req, $sformatf("%s out%0d", what, i), out_of(i), exp_m[i]);
      bus_rd(base_of[i], rd);
      check(req, $sformatf("%s read%0d", what, i), rd, exp_m[i]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    check_all("R1", "reset");
    bus_rd(12'h024, rd);
    check("R1", "input after reset", rd, 32'h0);
  endtask

  task automatic t_base_write;
    for (int i = 0; i < 6; i++) begin
      exp_m[i] = 32'hA5C3_0001 ^ (32'h1111_1111 * (i + 1));
      bus_wr(base_of[i], exp_m[i]);
      // R9: visible on the port right after the accepting edge
      check("R9", $sformatf("out%0d after write", i), out_of(i), exp_m[i]);
    end
    check_all("R2", "base write");
    check("R5", "level drives port", drv_lvl_o, exp_m[2]);
  endtask

  task automatic t_set_alias;
    logic [31:0] rd;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d = 32'h0F0F_0000 >> i;
      bus_wr(base_of[i] + 12'h4, d);
      exp_m[i] = exp_m[i] | d;
    end
    check_all("R3", "set alias");
    bus_rd(base_of[1] + 12'h4, rd);
    check("R7", "set alias read", rd, 32'h0);
  endtask

  task automatic t_clr_alias;
    logic [31:0] rd;
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d = 32'hFF00_00F0 << i;
      bus_wr(base_of[i] + 12'h8, d);
      exp_m[i] = exp_m[i] & ~d;
    end
    check_all("R4", "clr alias");
    bus_rd(base_of[4] + 12'h8, rd);
    check("R7", "clr alias read", rd, 32'h0);
    // zero write to clear alias has no effect
    bus_wr(base_of[0] + 12'h8, 32'h0);
    check("R4", "clr zero keeps", func_gpio_o, exp_m[0]);
  endtask

  task automatic t_single_pin;
    bus_wr(12'h000, 32'h0);      exp_m[0] = 32'h0;
    bus_wr(12'h004, 32'h8000_0000); exp_m[0] = 32'h8000_0000;
    check("R5", "pin31 gpio", func_gpio_o, 32'h8000_0000);
    bus_wr(12'h004, 32'h0000_0001); exp_m[0] = 32'h8000_0001;
    bus_wr(12'h008, 32'h8000_0000); exp_m[0] = 32'h0000_0001;
    check("R3", "pin0 kept", func_gpio_o, 32'h0000_0001);
  endtask

  task automatic t_low_bits;
    // R2: address bits [1:0] ignored
    bus_wr(12'h01B, 32'hDEAD_BEEF); exp_m[2] = 32'hDEAD_BEEF;
    check("R2", "low bits ignored", drv_lvl_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_input;
    logic [31:0] rd;
    pin_in = 32'h1234_5678;
    @(posedge clk); @(negedge clk);
    bus_rd(12'h024, rd); // one edge seen at sample time
    check("R6", "input one edge early", rd, 32'h0);
    bus_rd(12'h024, rd);
    check("R6", "input after two edges", rd, 32'h1234_5678);
    bus_wr(12'h024, 32'hFFFF_FFFF);
    check_all("R6", "write to input");
    bus_rd(12'h024, rd);
    check("R6", "input unchanged by write", rd, 32'h1234_5678);
  endtask

  task automatic t_unmapped;
    logic [11:0] holes [4] = '{12'h028, 12'h058, 12'h080, 12'hFFC};
    logic [31:0] rd;
    for (int k = 0; k < 4; k++) begin
      bus_wr(holes[k], 32'hFFFF_FFFF);
      bus_rd(holes[k], rd);
      check("R8", $sformatf("hole %h read", holes[k]), rd, 32'h0);
    end
    check_all("R8", "after hole writes");
  endtask

  task automatic t_idle;
    bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 12'h00C; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    bus_write = 1'b0;
    check("R9", "no valid no write", drv_en_o, exp_m[1]);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) exp_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_write();
    t_set_alias();
    t_clr_alias();
    t_single_pin();
    t_low_bits();
    t_input();
    t_unmapped();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule